// File: doc/BRIEF.md
# Effective Address Generator

This block forms the memory address for load and store micro-operations in an execution pipeline. Each request carries a base register value, an index register value, the program counter of the operation, a displacement field with a width selector, a two-bit scale code and a three-bit mode. From these it computes one address with a single three-input adder. The address appears one clock later in an output register, together with a valid strobe.

Six addressing modes share that adder by steering its three operands:

- the displacement alone
- the base alone
- the base plus the displacement
- the base plus the index
- the shifted index plus the base plus the displacement
- the program counter plus the displacement

The displacement is narrowed to its selected width and then sign-extended to the full address width. A mode code outside the six is flagged as illegal and yields a zero address. Register file reads, translation and the memory access itself belong to neighbouring blocks.

Top module: `agu_addr_gen`

## Requirements
- R1: A request accepted with `req_valid` high at a rising clock edge drives `ea_valid` high and the computed `ea_addr` on the following cycle. A cycle with `req_valid` low drives `ea_valid` low on the following cycle.
- R2: Mode 3'b000 (absolute) yields the sign-extended displacement as the address; base, index and PC have no effect.
- R3: Mode 3'b001 (register indirect) yields `base_val` unchanged; the displacement, index and scale have no effect.
- R4: Mode 3'b010 (base plus displacement) yields `base_val` plus the sign-extended displacement.
- R5: Mode 3'b011 (base plus index) yields `base_val + index_val`; the displacement and scale have no effect.
- R6: Mode 3'b100 (scaled) yields `base_val + index_val * S + disp`. S is 1, 2, 4 or 8 for `scale_sel` values 2'b00, 2'b01, 2'b10 and 2'b11.
- R7: Mode 3'b101 (PC-relative) yields `pc_val` plus the sign-extended displacement.
- R8: The displacement width is set by `disp_size`:
  - 2'b00 takes `disp_raw[7:0]`.
  - 2'b01 takes `disp_raw[15:0]`.
  - 2'b10 and 2'b11 take `disp_raw[31:0]`.
  - The selected field is sign-extended from its top bit, and bits above it have no effect.
- R9: All sums are taken modulo 2^AW; overflow wraps with no indication.
- R10: Modes 3'b110 and 3'b111 yield an all-zero address with `ea_illegal` high. Every other mode yields `ea_illegal` low.
- R11: While `req_valid` is low, `ea_addr` and `ea_illegal` keep their previous values.
- R12: While `rst_n` is low, `ea_valid`, `ea_illegal` and `ea_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code |
| base_val | input | AW | Base register value |
| index_val | input | AW | Index register value |
| pc_val | input | AW | Program counter of the operation |
| disp_raw | input | 32 | Raw displacement field |
| disp_size | input | 2 | Displacement width selector |
| scale_sel | input | 2 | Index shift amount |
| ea_valid | output | 1 | Address valid |
| ea_addr | output | AW | Registered effective address |
| ea_illegal | output | 1 | Request had an unused mode code |

## Verification
The bench targets displacements whose top selected bit is set, with garbage placed above the field. A design that extends from the wrong bit, or lets upper bits leak, produces addresses off by a power of two. Every scale code is exercised in scaled mode, and non-zero scale and displacement are sent in the modes that must ignore them. A design that applies the scale or displacement outside scaled mode, or swaps shift amounts, then gives a wrong sum. Requests near the top of the address space check for silent wraparound, and the two unused mode codes must yield zero with the flag set. Idle cycles between requests confirm that a design which updates its address without a valid request is caught.

// File: rtl/agu_addr_gen.sv
module agu_addr_gen #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic [AW-1:0] pc_val,
  input  logic [31:0]   disp_raw,
  input  logic [1:0]    disp_size,
  input  logic [1:0]    scale_sel,
  output logic          ea_valid,
  output logic [AW-1:0] ea_addr,
  output logic          ea_illegal
);
  localparam logic [2:0] M_ABS  = 3'd0;
  localparam logic [2:0] M_IND  = 3'd1;
  localparam logic [2:0] M_BD   = 3'd2;
  localparam logic [2:0] M_BI   = 3'd3;
  localparam logic [2:0] M_SIB  = 3'd4;
  localparam logic [2:0] M_PCR  = 3'd5;

  logic [AW-1:0] disp_ext;
  logic [AW-1:0] idx_shift;
  logic [AW-1:0] op_a, op_b, op_c;
  logic          bad_mode;
  logic [AW-1:0] sum;

  always_comb begin
    case (disp_size)
      2'b00:   disp_ext = {{(AW-8){disp_raw[7]}},   disp_raw[7:0]};
      2'b01:   disp_ext = {{(AW-16){disp_raw[15]}}, disp_raw[15:0]};
      default: disp_ext = {{(AW-32){disp_raw[31]}}, disp_raw[31:0]};
    endcase
  end

  assign idx_shift = index_val << scale_sel;

  always_comb begin
    op_a     = '0;
    op_b     = '0;
    op_c     = '0;
    bad_mode = 1'b0;
    case (mode)
      M_ABS: op_c = disp_ext;
      M_IND: op_a = base_val;
      M_BD:  begin op_a = base_val; op_c = disp_ext; end
      M_BI:  begin op_a = base_val; op_b = index_val; end
      M_SIB: begin op_a = base_val; op_b = idx_shift; op_c = disp_ext; end
      M_PCR: begin op_a = pc_val;   op_c = disp_ext; end
      default: bad_mode = 1'b1;
    endcase
  end

  assign sum = op_a + op_b + op_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_valid   <= 1'b0;
      ea_addr    <= '0;
      ea_illegal <= 1'b0;
    end else begin
      ea_valid <= req_valid;
      if (req_valid) begin
        ea_addr    <= sum;
        ea_illegal <= bad_mode;
      end
    end
  end
endmodule

module agu_addr_gen_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [2:0]    mode,
  input logic [AW-1:0] base_val,
  input logic [AW-1:0] index_val,
  input logic          ea_valid,
  input logic [AW-1:0] ea_addr,
  input logic          ea_illegal
);
  always @(negedge clk)
    if (!rst_n) a_r12_reset_quiet: assert (!ea_valid && !ea_illegal && ea_addr == '0);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ea_valid);
  a_r1_idle_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !ea_valid);
  a_r3_indirect_base: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 3'd1) |=> ea_addr == $past(base_val));
  a_r5_base_index: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 3'd3) |=> ea_addr == $past(base_val) + $past(index_val));
  a_r10_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode >= 3'd6) |=> (ea_illegal && ea_addr == '0));
  a_r10_good_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode < 3'd6) |=> !ea_illegal);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(ea_addr) && $stable(ea_illegal)));
endmodule

bind agu_addr_gen agu_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
  .base_val(base_val), .index_val(index_val),
  .ea_valid(ea_valid), .ea_addr(ea_addr), .ea_illegal(ea_illegal)
);

// File: tb/agu_addr_gen_test.sv
`timescale 1ns/1ps
module agu_addr_gen_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic [2:0]  mode = 0;
  logic [63:0] base_val = 0, index_val = 0, pc_val = 0;
  logic [31:0] disp_raw = 0;
  logic [1:0]  disp_size = 0, scale_sel = 0;
  logic        ea_valid, ea_illegal;
  logic [63:0] ea_addr;

  int total = 0, bad = 0;
  bit done = 0;
  logic [63:0] m_addr = 0;
  logic        m_ill = 0;

  always #4 clk = ~clk;

  agu_addr_gen #(.AW(64)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .base_val(base_val), .index_val(index_val), .pc_val(pc_val),
    .disp_raw(disp_raw), .disp_size(disp_size), .scale_sel(scale_sel),
    .ea_valid(ea_valid), .ea_addr(ea_addr), .ea_illegal(ea_illegal)
  );

  function automatic longint sx(logic [31:0] d, logic [1:0] sz);
    byte sb; shortint ss; int si;
    sb = d[7:0]; ss = d[15:0]; si = d;
    if (sz == 0) return longint'(sb);
    if (sz == 1) return longint'(ss);
    return longint'(si);
  endfunction

  task automatic check(string tag, logic v, logic [63:0] a, logic il);
    total++;
    if (ea_valid !== v || ea_addr !== a || ea_illegal !== il) begin
      bad++;
      $display("FAIL %s: got v=%b a=%h il=%b expected v=%b a=%h il=%b",
               tag, ea_valid, ea_addr, ea_illegal, v, a, il);
    end
  endtask

  task automatic req(string tag, logic [2:0] md, logic [63:0] b, logic [63:0] x,
                     logic [63:0] p, logic [31:0] d, logic [1:0] dz, logic [1:0] sc);
    longint e;
    req_valid = 1; mode = md; base_val = b; index_val = x; pc_val = p;
    disp_raw = d; disp_size = dz; scale_sel = sc;
    e = sx(d, dz);
    m_ill = 0;
    case (md)
      0: m_addr = e;
      1: m_addr = b;
      2: m_addr = b + e;
      3: m_addr = b + x;
      4: m_addr = b + x * (64'd1 << sc) + e;
      5: m_addr = p + e;
      default: begin m_addr = 0; m_ill = 1; end
    endcase
    @(negedge clk);
    check(tag, 1'b1, m_addr, m_ill);
  endtask

  task automatic idle(string tag);
    req_valid = 0; mode = 3'd2; base_val = 64'hDEAD; disp_raw = 32'h55;
    @(negedge clk);
    check(tag, 1'b0, m_addr, m_ill);
  endtask

  initial begin
    #(8 * 20000);
    bad++;
    $display("FAIL watchdog: got hang expected finish");
    if (!done) $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R12 reset", 1'b0, 64'd0, 1'b0);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle after reset", 1'b0, 64'd0, 1'b0);

    req("R2 absolute neg8", 3'd0, 64'h1234, 64'h99, 64'h7000, 32'hFFFF_FF80, 2'b00, 2'b11);
    req("R2 absolute 32", 3'd0, 64'h1, 64'h2, 64'h3, 32'h8000_0000, 2'b10, 2'b00);
    req("R3 indirect", 3'd1, 64'hCAFE_F00D_0000_1000, 64'h77, 64'h5, 32'h7F, 2'b00, 2'b10);
    req("R4 base disp16 neg", 3'd2, 64'h1_0000, 64'h0, 64'h0, 32'hABCD_8000, 2'b01, 2'b01);
    req("R4 base disp8 pos", 3'd2, 64'h100, 64'h0, 64'h0, 32'hFFFF_FF7F, 2'b00, 2'b00);
    req("R5 base index", 3'd3, 64'h4000, 64'h123, 64'h0, 32'h44, 2'b10, 2'b11);
    for (int s = 0; s < 4; s++)
      req("R6 scaled", 3'd4, 64'h1000, 64'h10 + s, 64'h0, 32'hFFFF_FFF0, 2'b00, s[1:0]);
    req("R6 scaled disp32", 3'd4, 64'h0, 64'h0FFF_FFFF_FFFF_FFFF, 64'h0, 32'h0000_0008, 2'b11, 2'b11);
    req("R7 pc rel", 3'd5, 64'h9, 64'h9, 64'h8000_0000_0000_0040, 32'hFFFF_FFC0, 2'b10, 2'b00);
    req("R8 size11 as 32", 3'd5, 64'h0, 64'h0, 64'h100, 32'hFFFF_FF00, 2'b11, 2'b00);
    req("R8 upper ignored", 3'd0, 64'h0, 64'h0, 64'h0, 32'h1234_0005, 2'b00, 2'b00);
    req("R9 wrap", 3'd2, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 64'h0, 32'h20, 2'b00, 2'b00);
    req("R9 wrap scaled", 3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 64'h0, 32'h1, 2'b00, 2'b01);
    idle("R11 hold after good");
    idle("R1 idle again");
    req("R10 mode6", 3'd6, 64'h55, 64'h66, 64'h77, 32'h88, 2'b00, 2'b01);
    idle("R11 hold illegal");
    req("R10 mode7", 3'd7, 64'h1, 64'h1, 64'h1, 32'h1, 2'b10, 2'b10);
    req("R10 legal clears", 3'd1, 64'hABC, 64'h0, 64'h0, 32'h0, 2'b00, 2'b00);
    idle("R11 hold final");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule